// File: doc/BRIEF.md
# Constant-Weight Six-Wire Symbol Codec

This block carries binary data over a parallel multi-wire link in which every symbol drives a fixed number of wires high. The configuration built uses six wires with exactly three of them high in every symbol. Such a link has twenty legal symbols. Sixteen of them carry a 4-bit data word, and the other four are held in reserve. Because the number of high wires is constant, the link is balanced in the same way a differential pair is, but it needs fewer wires per bit.

The transmit half takes a 4-bit word with a strobe and returns the matching 6-bit symbol one cycle later. The receive half takes a 6-bit symbol with a strobe and returns the 4-bit word, a valid flag and an error flag one cycle later. The receiver flags any symbol that has the wrong weight, and any legal-weight symbol that is not in the codebook. An error that moves one legal codeword onto another legal codeword cannot be seen by this check and decodes as the other value.

Top module: `nck_symbol_codec`

## Requirements
- R1: The transmitter maps data value d (0 to 15) to the d-th six-bit value, counting from 0, in ascending numeric order among the values with exactly three ones. For example, 0 maps to 000111, 1 maps to 001011 and 15 maps to 101100.
- R2: Every symbol that the transmitter presents with its output valid high has exactly three ones.
- R3: The transmitter output valid goes high in the cycle after an input strobe, and the symbol for that strobe appears in that same cycle.
- R4: The receiver returns d, with the error flag low, for each of the 16 codewords defined by R1.
- R5: A received symbol whose weight is not three sets the error flag and returns data zero. This covers every odd number of flipped wires.
- R6: The four reserved three-one symbols 110001, 110010, 110100 and 111000 set the error flag and return data zero.
- R7: The receiver output valid goes high in the cycle after an input strobe. The error flag is only ever high in a cycle where the output valid is high.
- R8: In a cycle after which no strobe was given, that side's output valid and error flag are low, and its data or symbol output keeps its previous value.
- R9: A synchronous active-high reset clears every output to zero. Reset takes priority over the strobes.
- R10: An even number of flips that lands on another mapped codeword is not flagged. It decodes as that codeword's value: 000111 received as 001011 gives 1, and received as 100101 gives 11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_strobe_i | input | 1 | Transmit data strobe |
| tx_data_i | input | 4 | Data word to send |
| tx_valid_o | output | 1 | Transmit symbol valid |
| tx_sym_o | output | 6 | Constant-weight symbol to the wires |
| rx_strobe_i | input | 1 | Received symbol strobe |
| rx_sym_i | input | 6 | Symbol sampled from the wires |
| rx_valid_o | output | 1 | Decoded result valid |
| rx_data_o | output | 4 | Decoded data word, zero on error |
| rx_err_o | output | 1 | Received symbol is illegal or reserved |

## Verification
The hardest cases to reach are the reserved codewords and the even-flip errors that land on a legal symbol, because the transmitter never emits either. The bench reaches them by driving the receive symbol port directly, rather than looping the transmitter back. It sends the four reserved patterns, symbols with odd and even numbers of flips applied to a known codeword, and flips that turn one mapped codeword into another, so that the errors the codec cannot detect are shown to decode as a different value.

// File: rtl/nck_symbol_codec.sv
module nck_symbol_codec #(
  parameter int WIRES  = 6,
  parameter int WEIGHT = 3,
  parameter int DATA_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tx_strobe_i,
  input  logic [DATA_W-1:0] tx_data_i,
  output logic              tx_valid_o,
  output logic [WIRES-1:0]  tx_sym_o,
  input  logic              rx_strobe_i,
  input  logic [WIRES-1:0]  rx_sym_i,
  output logic              rx_valid_o,
  output logic [DATA_W-1:0] rx_data_o,
  output logic              rx_err_o
);
  localparam int CODES = 1 << DATA_W;
  localparam int SPACE = 1 << WIRES;

  function automatic logic [WIRES-1:0] code_of(input logic [DATA_W-1:0] d);
    int rank;
    code_of = '0;
    rank = 0;
    for (int v = 0; v < SPACE; v++) begin
      if ($countones(v[WIRES-1:0]) == WEIGHT) begin
        if (rank == int'(d)) code_of = v[WIRES-1:0];
        rank++;
      end
    end
  endfunction

  function automatic logic [DATA_W:0] rank_of(input logic [WIRES-1:0] s);
    int rank;
    rank_of = {1'b1, {DATA_W{1'b0}}};
    rank = 0;
    for (int v = 0; v < SPACE; v++) begin
      if ($countones(v[WIRES-1:0]) == WEIGHT) begin
        if (v[WIRES-1:0] == s && rank < CODES) rank_of = {1'b0, rank[DATA_W-1:0]};
        rank++;
      end
    end
  endfunction

  logic [WIRES-1:0] tx_code;
  logic [DATA_W:0]  rx_res;

  assign tx_code = code_of(tx_data_i);
  assign rx_res  = rank_of(rx_sym_i);

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_valid_o <= 1'b0;
      tx_sym_o   <= '0;
      rx_valid_o <= 1'b0;
      rx_data_o  <= '0;
      rx_err_o   <= 1'b0;
    end else begin
      tx_valid_o <= tx_strobe_i;
      if (tx_strobe_i) tx_sym_o <= tx_code;
      rx_valid_o <= rx_strobe_i;
      rx_err_o   <= rx_strobe_i & rx_res[DATA_W];
      if (rx_strobe_i) rx_data_o <= rx_res[DATA_W] ? '0 : rx_res[DATA_W-1:0];
    end
  end

  AST_TX_WEIGHT: assert property (@(posedge clk) disable iff (rst)
    tx_valid_o |-> $countones(tx_sym_o) == WEIGHT); // R2
  AST_TX_LATENCY: assert property (@(posedge clk) disable iff (rst)
    tx_strobe_i |=> tx_valid_o); // R3
  AST_TX_HOLD: assert property (@(posedge clk) disable iff (rst)
    !tx_strobe_i |=> !tx_valid_o && $stable(tx_sym_o)); // R8
  AST_TX_ROUNDTRIP: assert property (@(posedge clk) disable iff (rst)
    tx_strobe_i |=> rank_of(tx_sym_o) == {1'b0, $past(tx_data_i)}); // R1
  AST_RX_LATENCY: assert property (@(posedge clk) disable iff (rst)
    rx_strobe_i |=> rx_valid_o); // R7
  AST_RX_ERR_QUAL: assert property (@(posedge clk) disable iff (rst)
    rx_err_o |-> rx_valid_o && rx_data_o == '0); // R7
  AST_RX_BAD_WEIGHT: assert property (@(posedge clk) disable iff (rst)
    rx_strobe_i && $countones(rx_sym_i) != WEIGHT |=> rx_err_o && rx_data_o == '0); // R5
  AST_RX_HOLD: assert property (@(posedge clk) disable iff (rst)
    !rx_strobe_i |=> !rx_valid_o && !rx_err_o && $stable(rx_data_o)); // R8
endmodule

// File: tb/nck_symbol_codec_tb.sv
`timescale 1ns/1ps
module nck_symbol_codec_tb;
  logic       clk = 1'b0;
  logic       rst;
  logic       tx_strobe_i;
  logic [3:0] tx_data_i;
  logic       tx_valid_o;
  logic [5:0] tx_sym_o;
  logic       rx_strobe_i;
  logic [5:0] rx_sym_i;
  logic       rx_valid_o;
  logic [3:0] rx_data_o;
  logic       rx_err_o;
  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  nck_symbol_codec u_dut (
    .clk(clk), .rst(rst),
    .tx_strobe_i(tx_strobe_i), .tx_data_i(tx_data_i),
    .tx_valid_o(tx_valid_o), .tx_sym_o(tx_sym_o),
    .rx_strobe_i(rx_strobe_i), .rx_sym_i(rx_sym_i),
    .rx_valid_o(rx_valid_o), .rx_data_o(rx_data_o), .rx_err_o(rx_err_o)
  );

  localparam logic [5:0] BOOK [16] = '{
    6'b000111, 6'b001011, 6'b001101, 6'b001110, 6'b010011, 6'b010101, 6'b010110, 6'b011001,
    6'b011010, 6'b011100, 6'b100011, 6'b100101, 6'b100110, 6'b101001, 6'b101010, 6'b101100};

  // {symbol, expected data, expected error}
  localparam logic [10:0] BAD [12] = '{
    {6'b110001, 4'd0, 1'b1}, {6'b110010, 4'd0, 1'b1}, {6'b110100, 4'd0, 1'b1},
    {6'b111000, 4'd0, 1'b1}, {6'b000000, 4'd0, 1'b1}, {6'b111111, 4'd0, 1'b1},
    {6'b000110, 4'd0, 1'b1}, {6'b000100, 4'd0, 1'b1}, {6'b001111, 4'd0, 1'b1},
    {6'b011111, 4'd0, 1'b1}, {6'b001011, 4'd1, 1'b0}, {6'b100101, 4'd11, 1'b0}};

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  initial begin
    #200000;
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; tx_strobe_i = 1'b1; tx_data_i = 4'd9; rx_strobe_i = 1'b1; rx_sym_i = 6'b111111;
    repeat (3) @(negedge clk);
    chk("R9 tx_valid", tx_valid_o, 0);
    chk("R9 tx_sym", tx_sym_o, 0);
    chk("R9 rx_valid", rx_valid_o, 0);
    chk("R9 rx_data", rx_data_o, 0);
    chk("R9 rx_err", rx_err_o, 0);
    rst = 1'b0;

    for (int i = 0; i < 16; i++) begin
      tx_strobe_i = 1'b1; tx_data_i = 4'(i);
      rx_strobe_i = 1'b1; rx_sym_i = BOOK[i];
      @(negedge clk);
      chk("R1 tx_sym", tx_sym_o, BOOK[i]);
      chk("R2 weight", $countones(tx_sym_o), 3);
      chk("R3 tx_valid", tx_valid_o, 1);
      chk("R4 rx_data", rx_data_o, i);
      chk("R4 rx_err", rx_err_o, 0);
      chk("R7 rx_valid", rx_valid_o, 1);
    end

    for (int i = 0; i < 12; i++) begin
      rx_strobe_i = 1'b1; rx_sym_i = BAD[i][10:5];
      @(negedge clk);
      if (i < 4) begin
        chk("R6 rx_err", rx_err_o, 1);
        chk("R6 rx_data", rx_data_o, 0);
      end else if (i < 10) begin
        chk("R5 rx_err", rx_err_o, 1);
        chk("R5 rx_data", rx_data_o, 0);
      end else begin
        chk("R10 rx_err", rx_err_o, BAD[i][0]);
        chk("R10 rx_data", rx_data_o, BAD[i][4:1]);
      end
      chk("R7 rx_valid", rx_valid_o, 1);
    end

    tx_strobe_i = 1'b1; tx_data_i = 4'd15;
    rx_strobe_i = 1'b1; rx_sym_i = BOOK[6];
    @(negedge clk);
    chk("R1 last code", tx_sym_o, 6'b101100);
    tx_strobe_i = 1'b0; tx_data_i = 4'd2;
    rx_strobe_i = 1'b0; rx_sym_i = 6'b111111;
    @(negedge clk);
    chk("R8 tx_valid", tx_valid_o, 0);
    chk("R8 tx_sym", tx_sym_o, 6'b101100);
    chk("R8 rx_valid", rx_valid_o, 0);
    chk("R8 rx_err", rx_err_o, 0);
    chk("R8 rx_data", rx_data_o, 6);
    @(negedge clk);
    chk("R8 rx_data second", rx_data_o, 6);

    rx_strobe_i = 1'b1; rx_sym_i = 6'b000001;
    @(negedge clk);
    chk("R7 err with valid", rx_err_o & rx_valid_o, 1);
    rx_strobe_i = 1'b0;
    @(negedge clk);
    chk("R7 err drops", rx_err_o, 0);

    tx_strobe_i = 1'b1; rx_strobe_i = 1'b1; rx_sym_i = BOOK[3];
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    chk("R9 mid tx_sym", tx_sym_o, 0);
    chk("R9 mid rx_data", rx_data_o, 0);
    chk("R9 mid tx_valid", tx_valid_o, 0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule